// File: doc/BRIEF.md
# Byte-Sliced Four-Lane Data FIFO

This block holds the transmit and receive data of a serial controller in two FIFOs, each built from four byte-wide slices of 16 entries. The host side reaches a FIFO through two views. A 32-bit word access pushes or pops all four slices at once, giving 64 bytes of depth. A byte access touches only the slice chosen by a rotating pointer, giving 16 bytes of depth per slice. The shift engine side is a byte stream. It drains the transmit FIFO and fills the receive FIFO one slice at a time, in rotation order 0, 1, 2, 3, 0.

Level flags from both FIFOs are gathered into a sticky status register. A host clears bits by writing ones. A per-bit enable mask produces a single level-high interrupt. Host accesses that would overflow or underflow a FIFO, or that use both views in the same cycle, raise an illegal-access bit and leave the storage untouched.

Stream rules: the transmit stream offers `tx_s_data` whenever `tx_s_valid` is high, and one byte moves on each rising edge where `tx_s_valid` and `tx_s_ready` are both high. The receive stream accepts `rx_s_data` on each edge where `rx_s_valid` and `rx_s_ready` are both high. `rx_s_ready` falls when the slice due to be written next is full, so the engine must hold its byte until ready returns.

Top module: `byte_lane_fifo`

## Requirements
- R1: While `rst_n` is low, status reads 0, `irq` is 0, `tx_s_valid` is 0 and `rx_s_ready` is 1. A `soft_rst` cycle empties every slice of both FIFOs, returns both slice pointers to slice 0 and clears status. It leaves the enable mask unchanged.
- R2: A host word write stores byte k (bits 8k+7:8k) in slice k. The transmit stream then delivers bytes from slice 0 upward, so a word comes out least significant byte first.
- R3: A host byte write (data on `tx_wdata[7:0]`) goes to the slice named by a write pointer, which then advances 0→1→2→3→0. Stream pops advance a separate read pointer in the same way.
- R4: Receive stream bytes fill slices in rotation. A host word read returns {slice3, slice2, slice1, slice0} heads on `rx_rdata_word` in the cycle of the strobe. A byte read returns the head of the current read slice on `rx_rdata_byte` and advances that pointer.
- R5: Transmit flags, one cycle after the condition holds: bit 0 when fewer than 16 bytes are held in total, bit 1 when the FIFO is empty, bit 2 when at least 32 bytes are held, bit 3 when any slice holds 16.
- R6: Receive flags, one cycle after the condition holds: bit 5 when at least 8 bytes are held, bit 6 when every slice holds at least one byte, bit 7 when at least 32 bytes are held, bit 8 when any slice holds 16, bit 11 when the current read slice holds a byte.
- R7: Bit 12 is set after any of the following, and none of them changes storage or pointers: a word write while any slice is full, a byte write to a full slice, a word read while some slice is empty, a byte read from an empty slice, or word and byte strobes of one direction in the same cycle.
- R8: Status bits are sticky. A 1 on `stat_clr[i]` zeroes bit i at the next edge and takes priority over a set in that cycle. A condition that still holds sets the bit again one edge later.
- R9: `irq` is high whenever some status bit and its enable bit are both 1. The enable register resets to bit 12 only and is loaded from `en_wdata` when `en_we` is high.
- R10: `tx_s_valid` is high exactly when the current transmit read slice is non-empty. While `tx_s_ready` is low, `tx_s_valid` and `tx_s_data` hold. `rx_s_ready` is high exactly when the current receive write slice is not full, and a byte offered while it is low is dropped by the handshake.
- R11: A host write and a stream pop on the transmit FIFO in the same cycle both take effect, even when they touch the same slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both FIFOs and status |
| tx_wr_word | input | 1 | Host word write strobe, transmit FIFO |
| tx_wr_byte | input | 1 | Host byte write strobe, transmit FIFO |
| tx_wdata | input | 32 | Host write data; the byte view uses bits 7:0 |
| tx_s_valid | output | 1 | Transmit stream byte available |
| tx_s_ready | input | 1 | Shift engine takes the transmit byte |
| tx_s_data | output | 8 | Transmit stream byte |
| rx_s_valid | input | 1 | Shift engine offers a received byte |
| rx_s_ready | output | 1 | Receive FIFO can take a byte |
| rx_s_data | input | 8 | Received byte |
| rx_rd_word | input | 1 | Host word read strobe, receive FIFO |
| rx_rd_byte | input | 1 | Host byte read strobe, receive FIFO |
| rx_rdata_word | output | 32 | Heads of all four receive slices |
| rx_rdata_byte | output | 8 | Head of the current receive read slice |
| stat_clr | input | 13 | Write-one-to-clear mask for status |
| en_we | input | 1 | Load the interrupt enable mask |
| en_wdata | input | 13 | New interrupt enable mask |
| status | output | 13 | Sticky status flags |
| irq | output | 1 | Level-high interrupt |

## Verification
The transmit FIFO can see a host word write and a shift-engine pop in the same cycle. When one byte sits in slice 0, that slice is read and written at the same edge. The bench provokes this by raising `tx_wr_word` and `tx_s_ready` together with one byte waiting. It judges the result from the popped byte and from the full order of the four bytes that follow, which must continue from slice 1 and end with the new byte 0. A second overlap is both host views strobed together. It must raise the illegal bit and leave `tx_s_valid` low.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam int STAT_W     = 13;
  localparam int B_TX_TRIG  = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_TX_HALF  = 2;
  localparam int B_TX_FULL  = 3;
  localparam int B_RX_TRIG  = 5;
  localparam int B_RX_WORD  = 6;
  localparam int B_RX_HALF  = 7;
  localparam int B_RX_FULL  = 8;
  localparam int B_RX_BYTE  = 11;
  localparam int B_ILLEGAL  = 12;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/bsf_slice.sv
// One byte-wide FIFO slice. DEPTH must be a power of two.
module bsf_slice #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  assign dout = mem[rp];
endmodule

// File: rtl/bsf_lanes.sv
// A set of parallel byte slices seen as one word FIFO or one rotating byte FIFO.
module bsf_lanes #(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              word_push,
  input  logic [LANES*8-1:0]                word_din,
  input  logic                              byte_push,
  input  logic [7:0]                        byte_din,
  input  logic                              word_pop,
  input  logic                              byte_pop,
  output logic [LANES*8-1:0]                word_dout,
  output logic [7:0]                        byte_dout,
  output logic                              any_full,
  output logic                              all_avail,
  output logic                              cur_wr_full,
  output logic                              cur_rd_avail,
  output logic [$clog2(LANES*DEPTH+1)-1:0]  total,
  output logic                              illegal
);
  localparam int LW = $clog2(LANES);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(LANES*DEPTH+1);

  logic [LW-1:0] wsel, rsel;
  logic [CW-1:0] sl_cnt  [LANES];
  logic [7:0]    sl_dout [LANES];
  logic          word_push_ok, byte_push_ok, word_pop_ok, byte_pop_ok;
  logic          bad_wr, bad_rd;

  function automatic logic [LW-1:0] next_sel(input logic [LW-1:0] s);
    return (s == LW'(LANES-1)) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    any_full  = 1'b0;
    all_avail = 1'b1;
    total     = '0;
    for (int i = 0; i < LANES; i++) begin
      if (sl_cnt[i] == CW'(DEPTH)) any_full  = 1'b1;
      if (sl_cnt[i] == '0)         all_avail = 1'b0;
      total = total + TW'(sl_cnt[i]);
    end
  end

  assign cur_wr_full  = (sl_cnt[wsel] == CW'(DEPTH));
  assign cur_rd_avail = (sl_cnt[rsel] != '0);
  assign byte_dout    = sl_dout[rsel];

  assign word_push_ok = word_push && !byte_push && !any_full;
  assign byte_push_ok = byte_push && !word_push && !cur_wr_full;
  assign word_pop_ok  = word_pop && !byte_pop && all_avail;
  assign byte_pop_ok  = byte_pop && !word_pop && cur_rd_avail;

  assign bad_wr = (word_push && byte_push) ||
                  (word_push && !byte_push && any_full) ||
                  (byte_push && !word_push && cur_wr_full);
  assign bad_rd = (word_pop && byte_pop) ||
                  (word_pop && !byte_pop && !all_avail) ||
                  (byte_pop && !word_pop && !cur_rd_avail);
  assign illegal = bad_wr || bad_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel <= '0;
      rsel <= '0;
    end else if (flush) begin
      wsel <= '0;
      rsel <= '0;
    end else begin
      if (byte_push_ok) wsel <= next_sel(wsel);
      if (byte_pop_ok)  rsel <= next_sel(rsel);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    logic       s_push, s_pop;
    logic [7:0] s_din;
    assign s_push = word_push_ok || (byte_push_ok && (wsel == LW'(g)));
    assign s_pop  = word_pop_ok  || (byte_pop_ok  && (rsel == LW'(g)));
    assign s_din  = word_push_ok ? word_din[8*g +: 8] : byte_din;
    assign word_dout[8*g +: 8] = sl_dout[g];

    bsf_slice #(.W(8), .DEPTH(DEPTH)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (s_push),
      .din   (s_din),
      .pop   (s_pop),
      .dout  (sl_dout[g]),
      .count (sl_cnt[g])
    );
  end
endmodule

// File: rtl/bsf_status.sv
// Sticky status with write-one-to-clear, enable mask and level interrupt.
module bsf_status
  import bsf_pkg::*;
#(
  parameter stat_t EN_RST = stat_t'(1) << B_ILLEGAL
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  stat_t cond,
  input  stat_t clr,
  input  logic  en_we,
  input  stat_t en_wdata,
  output stat_t status,
  output logic  irq
);
  stat_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= '0;
    else if (soft_rst) status <= '0;
    else               status <= (status | cond) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= EN_RST;
    else if (en_we) en_q <= en_wdata;
  end

  assign irq = |(status & en_q);
endmodule

// File: rtl/byte_lane_fifo.sv
module byte_lane_fifo
  import bsf_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DEPTH   = 16,
  parameter int TX_LOW  = 16,
  parameter int RX_HIGH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 tx_wr_word,
  input  logic                 tx_wr_byte,
  input  logic [LANES*8-1:0]   tx_wdata,
  output logic                 tx_s_valid,
  input  logic                 tx_s_ready,
  output logic [7:0]           tx_s_data,
  input  logic                 rx_s_valid,
  output logic                 rx_s_ready,
  input  logic [7:0]           rx_s_data,
  input  logic                 rx_rd_word,
  input  logic                 rx_rd_byte,
  output logic [LANES*8-1:0]   rx_rdata_word,
  output logic [7:0]           rx_rdata_byte,
  input  logic [STAT_W-1:0]    stat_clr,
  input  logic                 en_we,
  input  logic [STAT_W-1:0]    en_wdata,
  output logic [STAT_W-1:0]    status,
  output logic                 irq
);
  localparam int WW   = LANES*8;
  localparam int TW   = $clog2(LANES*DEPTH+1);
  localparam int HALF = (LANES*DEPTH)/2;

  logic          tx_any_full, tx_all_avail, tx_cur_wr_full, tx_cur_rd_avail, tx_illegal;
  logic          rx_any_full, rx_all_avail, rx_cur_wr_full, rx_cur_rd_avail, rx_illegal;
  logic [TW-1:0] tx_total, rx_total;
  logic [WW-1:0] tx_word_dout;
  logic          tx_pop, rx_push;
  stat_t         cond;
  logic          unused_tx;

  assign tx_s_valid = tx_cur_rd_avail;
  assign tx_pop     = tx_s_valid && tx_s_ready;
  assign rx_s_ready = !rx_cur_wr_full;
  assign rx_push    = rx_s_valid && rx_s_ready;

  bsf_lanes #(.LANES(LANES), .DEPTH(DEPTH)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (soft_rst),
    .word_push    (tx_wr_word),
    .word_din     (tx_wdata),
    .byte_push    (tx_wr_byte),
    .byte_din     (tx_wdata[7:0]),
    .word_pop     (1'b0),
    .byte_pop     (tx_pop),
    .word_dout    (tx_word_dout),
    .byte_dout    (tx_s_data),
    .any_full     (tx_any_full),
    .all_avail    (tx_all_avail),
    .cur_wr_full  (tx_cur_wr_full),
    .cur_rd_avail (tx_cur_rd_avail),
    .total        (tx_total),
    .illegal      (tx_illegal)
  );

  bsf_lanes #(.LANES(LANES), .DEPTH(DEPTH)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (soft_rst),
    .word_push    (1'b0),
    .word_din     ('0),
    .byte_push    (rx_push),
    .byte_din     (rx_s_data),
    .word_pop     (rx_rd_word),
    .byte_pop     (rx_rd_byte),
    .word_dout    (rx_rdata_word),
    .byte_dout    (rx_rdata_byte),
    .any_full     (rx_any_full),
    .all_avail    (rx_all_avail),
    .cur_wr_full  (rx_cur_wr_full),
    .cur_rd_avail (rx_cur_rd_avail),
    .total        (rx_total),
    .illegal      (rx_illegal)
  );

  assign unused_tx = ^{tx_word_dout, tx_all_avail, tx_cur_wr_full};

  always_comb begin
    cond             = '0;
    cond[B_TX_TRIG]  = (tx_total < TW'(TX_LOW));
    cond[B_TX_EMPTY] = (tx_total == '0);
    cond[B_TX_HALF]  = (tx_total >= TW'(HALF));
    cond[B_TX_FULL]  = tx_any_full;
    cond[B_RX_TRIG]  = (rx_total >= TW'(RX_HIGH));
    cond[B_RX_WORD]  = rx_all_avail;
    cond[B_RX_HALF]  = (rx_total >= TW'(HALF));
    cond[B_RX_FULL]  = rx_any_full;
    cond[B_RX_BYTE]  = rx_cur_rd_avail;
    cond[B_ILLEGAL]  = tx_illegal || rx_illegal;
  end

  bsf_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .cond     (cond),
    .clr      (stat_clr),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .status   (status),
    .irq      (irq)
  );
endmodule

// File: rtl/bsf_checker.sv
module bsf_checker
  import bsf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              tx_wr_word,
  input logic              tx_wr_byte,
  input logic              tx_s_valid,
  input logic              tx_s_ready,
  input logic [7:0]        tx_s_data,
  input logic              rx_s_ready,
  input logic              rx_rd_word,
  input logic              rx_rd_byte,
  input logic [STAT_W-1:0] stat_clr,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  // R1: a flush leaves nothing to send and room to receive
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!tx_s_valid && rx_s_ready));

  // R7: both host write views in one cycle are flagged
  a_r7_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_word && tx_wr_byte && !soft_rst && !stat_clr[B_ILLEGAL]) |=> status[B_ILLEGAL]);

  // R8: a clear beats any set in the same cycle
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr[B_ILLEGAL] |=> !status[B_ILLEGAL]);

  // R9: the interrupt needs some status bit
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));

  // R10: a stalled transmit byte holds
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_s_valid && !tx_s_ready && !soft_rst) |=> (tx_s_valid && $stable(tx_s_data)));

  // R10: back-pressure persists until the host drains
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_s_ready && !rx_rd_word && !rx_rd_byte && !soft_rst) |=> !rx_s_ready);
endmodule

bind byte_lane_fifo bsf_checker u_chk (.*);

// File: tb/sim_byte_lane_fifo.sv
module sim_byte_lane_fifo;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] arg;
    logic [31:0] exp;
  } vec_t;

  // ops: 0 tx word write, 1 tx byte write, 2 tx stream pop, 3 status snapshot,
  //      4 rx stream push, 5 rx word read, 6 rx byte read
  localparam vec_t TBL [20] = '{
    '{3'd3, 32'h0,        32'h003},
    '{3'd0, 32'h44332211, 32'h0},
    '{3'd1, 32'h55,       32'h0},
    '{3'd3, 32'h0,        32'h001},
    '{3'd2, 32'h0,        32'h11},
    '{3'd2, 32'h0,        32'h22},
    '{3'd2, 32'h0,        32'h33},
    '{3'd2, 32'h0,        32'h44},
    '{3'd2, 32'h0,        32'h55},
    '{3'd3, 32'h0,        32'h003},
    '{3'd4, 32'hA0,       32'h0},
    '{3'd4, 32'hA1,       32'h0},
    '{3'd4, 32'hA2,       32'h0},
    '{3'd3, 32'h0,        32'h803},
    '{3'd4, 32'hA3,       32'h0},
    '{3'd3, 32'h0,        32'h843},
    '{3'd5, 32'h0,        32'hA3A2A1A0},
    '{3'd4, 32'hB0,       32'h0},
    '{3'd6, 32'h0,        32'hB0},
    '{3'd3, 32'h0,        32'h003}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        tx_wr_word = 1'b0, tx_wr_byte = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_s_valid, tx_s_ready = 1'b0;
  logic [7:0]  tx_s_data;
  logic        rx_s_valid = 1'b0, rx_s_ready;
  logic [7:0]  rx_s_data = '0;
  logic        rx_rd_word = 1'b0, rx_rd_byte = 1'b0;
  logic [31:0] rx_rdata_word;
  logic [7:0]  rx_rdata_byte;
  logic [12:0] stat_clr = '0;
  logic        en_we = 1'b0;
  logic [12:0] en_wdata = '0;
  logic [12:0] status;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  byte_lane_fifo u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tx_word(input logic [31:0] d);
    tx_wr_word = 1'b1; tx_wdata = d; cyc(); tx_wr_word = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] d);
    tx_wr_byte = 1'b1; tx_wdata = {24'h0, d}; cyc(); tx_wr_byte = 1'b0;
  endtask

  task automatic tx_pop(input string req, input logic [7:0] e);
    chk(req, {23'h0, tx_s_valid, tx_s_data}, {23'h0, 1'b1, e});
    tx_s_ready = 1'b1; cyc(); tx_s_ready = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_s_valid = 1'b1; rx_s_data = d; cyc(); rx_s_valid = 1'b0;
  endtask

  task automatic snap(input string req, input logic [12:0] e);
    stat_clr = '1; cyc(); stat_clr = '0; cyc();
    chk(req, {19'h0, status}, {19'h0, e});
  endtask

  task automatic sreset();
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
  endtask

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while held in reset
    chk("R1 reset status", {19'h0, status}, 32'h0);
    chk("R1 reset flags", {29'h0, irq, tx_s_valid, rx_s_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 20; i++) begin
      case (TBL[i].op)
        3'd0: tx_word(TBL[i].arg);
        3'd1: tx_byte(TBL[i].arg[7:0]);
        3'd2: tx_pop("R2/R3 stream order", TBL[i].exp[7:0]);
        3'd3: snap("R5/R6 flags", TBL[i].exp[12:0]);
        3'd4: rx_push(TBL[i].arg[7:0]);
        3'd5: begin
          chk("R4 word read", rx_rdata_word, TBL[i].exp);
          rx_rd_word = 1'b1; cyc(); rx_rd_word = 1'b0;
        end
        default: begin
          chk("R4 byte read", {24'h0, rx_rdata_byte}, TBL[i].exp);
          rx_rd_byte = 1'b1; cyc(); rx_rd_byte = 1'b0;
        end
      endcase
    end

    // R1: soft reset drops held data and rewinds the pointers
    tx_byte(8'h99);
    chk("R1 pre-flush valid", {31'h0, tx_s_valid}, 32'h1);
    sreset();
    chk("R1 flush empties", {31'h0, tx_s_valid}, 32'h0);
    tx_byte(8'h77);
    tx_pop("R1 pointer rewound", 8'h77);

    // R5: half and full
    sreset();
    for (int k = 0; k < 8; k++)
      tx_word({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    snap("R5 half", 13'h004);
    for (int k = 8; k < 16; k++)
      tx_word({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    snap("R5 full", 13'h00C);

    // R7 R9: overflow flagged and raises irq
    tx_word(32'hDEADBEEF);
    chk("R7 overflow flag", {31'h0, status[12]}, 32'h1);
    chk("R9 irq on illegal", {31'h0, irq}, 32'h1);
    for (int k = 0; k < 64; k++) tx_pop("R2 drain order", 8'(k));
    chk("R7 overflow not stored", {31'h0, tx_s_valid}, 32'h0);

    // R8: clear and re-assert
    stat_clr = 13'h1000; cyc(); stat_clr = '0;
    chk("R8 cleared", {31'h0, status[12]}, 32'h0);
    chk("R9 irq drops", {31'h0, irq}, 32'h0);
    stat_clr = 13'h0002; cyc(); stat_clr = '0;
    chk("R8 clear held condition", {31'h0, status[1]}, 32'h0);
    cyc();
    chk("R8 re-assert", {31'h0, status[1]}, 32'h1);

    // R9: enable mask
    en_we = 1'b1; en_wdata = 13'h0002; cyc(); en_we = 1'b0;
    chk("R9 enabled bit", {31'h0, irq}, 32'h1);
    en_we = 1'b1; en_wdata = 13'h1000; cyc(); en_we = 1'b0;
    chk("R9 masked bit", {31'h0, irq}, 32'h0);

    // R7: read of empty receive FIFO
    rx_rd_byte = 1'b1; cyc(); rx_rd_byte = 1'b0;
    chk("R7 underflow flag", {31'h0, status[12]}, 32'h1);

    // R6 R10: receive fills to full and back-pressures
    sreset();
    for (int k = 0; k < 64; k++) rx_push(8'(k));
    chk("R10 ready low when full", {31'h0, rx_s_ready}, 32'h0);
    rx_push(8'hEE);
    snap("R6 all receive flags", 13'h9E3);
    for (int k = 0; k < 16; k++) begin
      chk("R4 word order", rx_rdata_word, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
      rx_rd_word = 1'b1; cyc(); rx_rd_word = 1'b0;
    end
    snap("R10 dropped byte not stored", 13'h003);

    // R11: host write and stream pop together on slice 0
    sreset();
    tx_byte(8'h10);
    chk("R11 head before overlap", {24'h0, tx_s_data}, 32'h10);
    tx_wr_word = 1'b1; tx_wdata = 32'h03020100; tx_s_ready = 1'b1;
    cyc();
    tx_wr_word = 1'b0; tx_s_ready = 1'b0;
    tx_pop("R11 after overlap", 8'h01);
    tx_pop("R11 after overlap", 8'h02);
    tx_pop("R11 after overlap", 8'h03);
    tx_pop("R11 after overlap", 8'h00);
    chk("R11 nothing extra", {31'h0, tx_s_valid}, 32'h0);

    // R7: both write views at once
    stat_clr = '1; cyc(); stat_clr = '0;
    tx_wr_word = 1'b1; tx_wr_byte = 1'b1; tx_wdata = 32'h12345678; cyc();
    tx_wr_word = 1'b0; tx_wr_byte = 1'b0;
    chk("R7 dual view flag", {31'h0, status[12]}, 32'h1);
    chk("R7 dual view not stored", {31'h0, tx_s_valid}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule